// File: doc/BRIEF.md
# Two-Read One-Write Register File with Hardwired Zero Entry

This block is the integer register file of a single-issue datapath. It holds 32 words of 32 bits. Two read ports and one write port are usable in the same cycle. Entry 0 has no storage. It reads as zero and silently drops any write aimed at it.

Every other entry is a bank of flip-flops. Each bank is loaded on the rising clock edge when the write-enable is high and its decoded select line is set. Each read port is a pure multiplexer from its address to its data output, so read data follows the address within the same cycle. A read of the entry being written returns the stored value until the edge. There is no bypass path. An active-low asynchronous reset clears every entry.

Top module: `rf_2r1w`

## Requirements
- R1: With `wr_en_i` high, the rising edge of `clk_i` stores `wr_data_i` into the entry selected by the 5-bit `wr_addr_i` (1..31). After that edge, either read port addressing that entry returns the stored word.
- R2: A read address of 0 on either port gives an output of all zeros.
- R3: A write with `wr_addr_i` = 0 changes no entry. Entry 0 still reads as zero, and entries 1..31 keep their contents.
- R4: While `wr_en_i` is low, `wr_addr_i` and `wr_data_i` have no effect on any entry.
- R5: Read outputs are combinational. A new read address produces the addressed entry's data in the same cycle, without a clock edge.
- R6: During a write cycle, a read of the target entry returns its old contents until the clock edge.
- R7: When both read ports carry the same address, they return identical data.
- R8: An entry keeps its value until it is written again. Writes to other entries leave it unchanged.
- R9: Driving `rst_ni` low clears entries 1..31 to zero at once, without waiting for a clock edge.
- R10: Every bit of every entry 1..31 can hold both 0 and 1. Writing all-zeros and all-ones reads back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write entry index |
| wr_data_i | input | 32 | Write word |
| rd_addr_a_i | input | 5 | Read port A entry index |
| rd_data_a_o | output | 32 | Read port A word |
| rd_addr_b_i | input | 5 | Read port B entry index |
| rd_data_b_o | output | 32 | Read port B word |

## Verification
Read results are due in the same cycle as the address, so the bench changes an address and compares the output one nanosecond later, well before the next edge. A write lands exactly one rising edge after the stimulus is applied. The bench drives write inputs one nanosecond after an edge and holds them for one period. It checks the old value before that edge and the new value after it, and updates its model only at that edge. Reset clears the entries without a clock, so that check is sampled while reset is still low and away from any edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int RF_NUM_REGS = 32;
  parameter int RF_DATA_W   = 32;
endpackage

// File: rtl/rf_wr_dec.sv
module rf_wr_dec #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    if (k == 0) begin : g_zero
      assign sel_o[k] = 1'b0;  // entry 0 never selected
    end else begin : g_live
      assign sel_o[k] = en_i && (addr_i == ADDR_W'(k));
    end
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              sel_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  rf_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_row
    if (k == 0) begin : g_zero
      assign rf_o[k] = '0;
    end else begin : g_ff
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (sel_i[k]) q <= data_i;
      end
      assign rf_o[k] = q;
    end
  end
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  rf_i,
  output logic [DATA_W-1:0]                data_o
);
  // NUM_REGS is a power of two, so every address is in range
  assign data_o = rf_i[addr_i];
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w
  import rf_pkg::*;
#(
  parameter int NUM_REGS = RF_NUM_REGS,
  parameter int DATA_W   = RF_DATA_W,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o
);
  logic [NUM_REGS-1:0]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] rf_q;

  rf_wr_dec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .en_i(wr_en_i), .addr_i(wr_addr_i), .sel_o(wr_sel)
  );

  rf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(wr_sel),
    .data_i(wr_data_i), .rf_o(rf_q)
  );

  rf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .addr_i(rd_addr_a_i), .rf_i(rf_q), .data_o(rd_data_a_o)
  );

  rf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .addr_i(rd_addr_b_i), .rf_i(rf_q), .data_o(rd_data_b_o)
  );

  // R1
  wr_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=> rf_q[$past(wr_addr_i)] == $past(wr_data_i));

  // R2
  rd_zero_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> (rd_data_a_o == '0));

  // R2
  rd_zero_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_b_i == '0) |-> (rd_data_b_o == '0));

  // R3
  wr_zero_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0) |=> $stable(rf_q));

  // R4
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rf_q));

  // R4
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel));

  // R7
  same_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == rd_addr_b_i) |-> (rd_data_a_o == rd_data_b_o));
endmodule

// File: tb/rf_2r1w_tb.sv
`timescale 1ns/1ps
module rf_2r1w_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  rd_addr_a_i = '0;
  logic [31:0] rd_data_a_o;
  logic [4:0]  rd_addr_b_i = '0;
  logic [31:0] rd_data_b_o;

  logic [31:0] mdl [32];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rf_2r1w u_dut (.*);

  function automatic logic [31:0] uniq(input int i);
    return 32'hC3A50000 ^ (32'(i) * 32'h01010101) ^ 32'(i << 8);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    return (a == 5'd0) ? 32'h0 : mdl[a];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reads are combinational: sample 1 ns after the address changes
  task automatic rd(input string req, input logic [4:0] a, input logic [4:0] b);
    rd_addr_a_i = a; rd_addr_b_i = b;
    #1;
    chk(req, rd_data_a_o, exp_rd(a));
    chk(req, rd_data_b_o, exp_rd(b));
  endtask

  task automatic wr(input logic we, input logic [4:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    rd_addr_a_i = a; #1;
    chk("R6", rd_data_a_o, exp_rd(a));  // old value before the edge
    @(posedge clk_i);
    if (we && a != 5'd0) mdl[a] = d;
    #1 wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R9 reset state
    for (int i = 0; i < 32; i++) rd("R9", 5'(i), 5'(31 - i));

    // R1/R8 unique value per entry, then read back through both ports
    for (int i = 1; i < 32; i++) wr(1'b1, 5'(i), uniq(i));
    for (int i = 0; i < 32; i++) rd("R1", 5'(i), 5'(31 - i));
    for (int i = 0; i < 32; i++) rd("R8", 5'((i + 7) % 32), 5'(i));

    // R2/R3 write to entry 0
    wr(1'b1, 5'd0, 32'hFFFF_FFFF);
    rd("R2", 5'd0, 5'd0);
    for (int i = 1; i < 32; i++) rd("R3", 5'(i), 5'd0);

    // R4 enable low with live address/data
    wr(1'b0, 5'd5, 32'hDEAD_BEEF);
    wr(1'b0, 5'd31, 32'h0);
    rd("R4", 5'd5, 5'd31);

    // R5 address change without a clock edge
    @(negedge clk_i);
    rd("R5", 5'd9, 5'd18);
    rd("R5", 5'd18, 5'd9);

    // R7 same address on both ports
    for (int i = 0; i < 32; i += 3) begin
      rd_addr_a_i = 5'(i); rd_addr_b_i = 5'(i); #1;
      chk("R7", rd_data_a_o, rd_data_b_o);
    end

    // R10 stuck-at: all zeros, then all ones
    for (int i = 1; i < 32; i++) wr(1'b1, 5'(i), 32'h0);
    for (int i = 1; i < 32; i++) rd("R10", 5'(i), 5'(i));
    for (int i = 1; i < 32; i++) wr(1'b1, 5'(i), 32'hFFFF_FFFF);
    for (int i = 1; i < 32; i++) rd("R10", 5'(i), 5'(32 - i));

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic        we;
      logic [4:0]  a;
      logic [31:0] d;
      we = ($urandom % 4) != 0;
      a  = 5'($urandom);
      case ($urandom % 5)
        0:       d = 32'h0;
        1:       d = 32'hFFFF_FFFF;
        default: d = $urandom;
      endcase
      wr(we, a, d);
      rd("R8", 5'($urandom), a);
    end

    // R9 async clear mid-run, sampled while reset is low
    @(posedge clk_i); #1.5;
    rst_ni = 1'b0;
    #0.5;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    for (int i = 0; i < 32; i++) rd("R9", 5'(i), 5'(31 - i));
    @(posedge clk_i); #1 rst_ni = 1'b1;
    wr(1'b1, 5'd17, 32'h1234_5678);
    rd("R1", 5'd17, 5'd16);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule